// File: doc/BRIEF.md
# PC-Relative Store Sequencer

This block is a 16-bit datapath slice built around one shared bus, with a small state machine that carries out a single PC-relative store instruction over three clock cycles. The slice contains a program counter, an instruction register, an eight-entry register file, an address adder fed by two operand selectors, a one-operand ALU, a memory address register (MAR), a memory data register (MDR) and a small word memory. Every transfer between these parts goes over the bus. The bus is modelled as a mux that is driven by at most one enabled source per cycle.

Software-side loading happens only while the block is idle. The surrounding logic writes registers through a write port, preloads or inspects memory through an external port, and loads the PC and the instruction word. A one-cycle `start` pulse then launches the store.

The controller moves through five states, each with its own control word:
- S_IDLE: waits for `start`, then goes to S_ADDR.
- S_ADDR: the adder computes PC plus the sign-extended offset in bits 8..0. The address-path mux forwards this sum, its gate drives the bus, and the MAR loads. The next state is S_DATA.
- S_DATA: the source register selected by bits 11..9 is read on register-file port A. The ALU passes it through and drives the bus. The MDR input mux picks the bus (memory enable low), and the MDR loads. The next state is S_WRITE.
- S_WRITE: memory enable and write are asserted together, so the word at the MAR address takes the MDR value. The next state is S_DONE.
- S_DONE: `done` is high for this one cycle, and the controller returns to S_IDLE.

Top module: `stseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the controller goes to idle and clears MAR, MDR and PC. After that edge, `busy`, `done`, `mar_out` and `mdr_out` read 0.
- R2: One edge after the start edge, `mar_out` equals (PC + sign-extend(instr[8:0])) mod 2^16. Bit 8 of the instruction is the offset sign.
- R3: One edge after MAR loads, `mdr_out` equals the register whose index is instr[11:9].
- R4: The memory word at index (effective address mod 2^AW) takes the source register value. `done` is high for exactly one cycle.
- R5: The store takes exactly 3 cycles. `busy` is high for three consecutive cycles after the start edge, and `done` follows in the fourth.
- R6: At most one bus driver, the address-path gate or the ALU gate, is enabled in any cycle. The bus therefore carries clean values.
- R7: The store leaves the PC, every register-file entry and every memory word other than the target unchanged.
- R8: `start`, `instr_load`, `pc_load`, `rf_we` and `ext_we` are ignored while the controller is not idle. A second start that arrives during a store neither loads a new instruction nor causes a second store.
- R9: Offsets at the extremes (-256, -1 and +255) wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the store from idle |
| instr_load | input | 1 | Loads `instr_in` into the instruction register (idle only) |
| instr_in | input | 16 | Store instruction word |
| pc_load | input | 1 | Loads `pc_in` into PC (idle only) |
| pc_in | input | 16 | New PC value |
| rf_we | input | 1 | Register-file write (idle only) |
| rf_waddr | input | 3 | Register-file write index |
| rf_wdata | input | 16 | Register-file write data |
| rf_oaddr | input | 3 | Observation read index |
| rf_odata | output | 16 | Observation read data |
| ext_we | input | 1 | External memory write (idle only) |
| ext_addr | input | 6 | External memory index |
| ext_wdata | input | 16 | External memory write data |
| ext_rdata | output | 16 | Memory word at `ext_addr` |
| pc_out | output | 16 | Current PC |
| mar_out | output | 16 | Current MAR |
| mdr_out | output | 16 | Current MDR |
| busy | output | 1 | High in the three store cycles |
| done | output | 1 | One-cycle completion pulse |

## Verification
Stores are run with a small positive offset, with -1, with -256 (which wraps the address to zero) and with +255 (which lands on the last memory word). Each store uses a different source register, so any error in sign extension, in the choice of offset field or in register indexing shows up as a wrong MAR or memory value.

A further store receives a second instruction load and start pulse in its middle. This separates a controller that ignores inputs while busy from one that restarts or reloads. After every store the whole memory image, all registers and the PC are compared against a bench model, which exposes stray writes.

// File: rtl/stseq_pkg.sv
package stseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_DATA,
        S_WRITE,
        S_DONE
    } st_t;

    typedef enum logic {
        A1_PC,
        A1_REG
    } a1_sel_t;

    typedef enum logic [1:0] {
        A2_ZERO,
        A2_OFF6,
        A2_OFF9,
        A2_OFF11
    } a2_sel_t;

    typedef enum logic {
        ALU_PASS,
        ALU_INV
    } alu_op_t;

    typedef struct packed {
        a1_sel_t addr1;
        a2_sel_t addr2;
        logic    amux_adder;
        logic    gate_amux;
        logic    gate_alu;
        logic    ld_mar;
        logic    ld_mdr;
        logic    mem_en;
        logic    mem_wr;
        alu_op_t alu_op;
        logic    sr_hi;
    } ctl_t;

endpackage

// File: rtl/stseq_ctrl.sv
module stseq_ctrl
    import stseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output st_t  state,
    output ctl_t ctl,
    output logic busy,
    output logic done
);

    st_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        ctl      = '0;
        state_nx = state;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) state_nx = S_ADDR;
            end
            S_ADDR: begin
                busy           = 1'b1;
                ctl.addr1      = A1_PC;
                ctl.addr2      = A2_OFF9;
                ctl.amux_adder = 1'b1;
                ctl.gate_amux  = 1'b1;
                ctl.ld_mar     = 1'b1;
                state_nx       = S_DATA;
            end
            S_DATA: begin
                busy         = 1'b1;
                ctl.sr_hi    = 1'b1;
                ctl.alu_op   = ALU_PASS;
                ctl.gate_alu = 1'b1;
                ctl.mem_en   = 1'b0;
                ctl.ld_mdr   = 1'b1;
                state_nx     = S_WRITE;
            end
            S_WRITE: begin
                busy       = 1'b1;
                ctl.mem_en = 1'b1;
                ctl.mem_wr = 1'b1;
                state_nx   = S_DONE;
            end
            S_DONE: begin
                done     = 1'b1;
                state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

endmodule

// File: rtl/stseq_regfile.sv
module stseq_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RAW-1:0] raddr_a,
    output logic [DW-1:0]  rdata_a,
    input  logic [RAW-1:0] raddr_o,
    output logic [DW-1:0]  rdata_o
);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                      regs[g] <= '0;
            else if (we && waddr == RAW'(g)) regs[g] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_o = regs[raddr_o];

endmodule

// File: rtl/stseq_mem.sv
module stseq_mem #(
    parameter int DW = 16,
    parameter int AW = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          st_we,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_wdata,
    output logic [DW-1:0] st_rdata,
    input  logic          x_we,
    input  logic [AW-1:0] x_addr,
    input  logic [DW-1:0] x_wdata,
    output logic [DW-1:0] x_rdata
);

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (st_we)     words[st_addr] <= st_wdata;
        else if (x_we) words[x_addr]  <= x_wdata;
    end

    assign st_rdata = words[st_addr];
    assign x_rdata  = words[x_addr];

endmodule

// File: rtl/stseq_top.sv
module stseq_top
    import stseq_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 6,
    parameter int NREG = 8,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           instr_load,
    input  logic [DW-1:0]  instr_in,
    input  logic           pc_load,
    input  logic [DW-1:0]  pc_in,
    input  logic           rf_we,
    input  logic [RAW-1:0] rf_waddr,
    input  logic [DW-1:0]  rf_wdata,
    input  logic [RAW-1:0] rf_oaddr,
    output logic [DW-1:0]  rf_odata,
    input  logic           ext_we,
    input  logic [AW-1:0]  ext_addr,
    input  logic [DW-1:0]  ext_wdata,
    output logic [DW-1:0]  ext_rdata,
    output logic [DW-1:0]  pc_out,
    output logic [DW-1:0]  mar_out,
    output logic [DW-1:0]  mdr_out,
    output logic           busy,
    output logic           done
);

    st_t  state;
    ctl_t ctl;
    logic idle;

    logic [DW-1:0] pc_q, ir_q, mar_q, mdr_q;
    logic [DW-1:0] sr_val, alu_out, addr1, addr2, adder_out, amux_out, bus;
    logic [DW-1:0] mem_rd, mdr_in;
    logic [RAW-1:0] sr_idx;

    stseq_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .state (state),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    assign idle = (state == S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ir_q <= '0;
        end else if (idle) begin
            if (pc_load)    pc_q <= pc_in;
            if (instr_load) ir_q <= instr_in;
        end
    end

    assign sr_idx = ctl.sr_hi ? ir_q[11:9] : ir_q[8:6];

    stseq_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we && idle),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (sr_idx),
        .rdata_a (sr_val),
        .raddr_o (rf_oaddr),
        .rdata_o (rf_odata)
    );

    function automatic logic [DW-1:0] sext(input logic [DW-1:0] v, input int bits);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = (i < bits) ? v[i] : v[bits-1];
        return r;
    endfunction

    always_comb begin
        addr1 = (ctl.addr1 == A1_PC) ? pc_q : sr_val;
        unique case (ctl.addr2)
            A2_ZERO:  addr2 = '0;
            A2_OFF6:  addr2 = sext(ir_q, 6);
            A2_OFF9:  addr2 = sext(ir_q, 9);
            A2_OFF11: addr2 = sext(ir_q, 11);
            default:  addr2 = '0;
        endcase
    end

    assign adder_out = addr1 + addr2;
    assign amux_out  = ctl.amux_adder ? adder_out : {{(DW-8){1'b0}}, ir_q[7:0]};
    assign alu_out   = (ctl.alu_op == ALU_PASS) ? sr_val : ~sr_val;

    always_comb begin
        unique case ({ctl.gate_amux, ctl.gate_alu})
            2'b10:   bus = amux_out;
            2'b01:   bus = alu_out;
            default: bus = '0;
        endcase
    end

    assign mdr_in = ctl.mem_en ? mem_rd : bus;

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q <= '0;
            mdr_q <= '0;
        end else begin
            if (ctl.ld_mar) mar_q <= bus;
            if (ctl.ld_mdr) mdr_q <= mdr_in;
        end
    end

    stseq_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk      (clk),
        .st_we    (ctl.mem_en && ctl.mem_wr),
        .st_addr  (mar_q[AW-1:0]),
        .st_wdata (mdr_q),
        .st_rdata (mem_rd),
        .x_we     (ext_we && idle),
        .x_addr   (ext_addr),
        .x_wdata  (ext_wdata),
        .x_rdata  (ext_rdata)
    );

    assign pc_out  = pc_q;
    assign mar_out = mar_q;
    assign mdr_out = mdr_q;

endmodule

// File: rtl/stseq_checker.sv
module stseq_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          gate_amux,
    input logic          gate_alu,
    input logic          ld_mar,
    input logic          ld_mdr,
    input logic          mem_wr,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] bus,
    input logic [DW-1:0] mar,
    input logic [DW-1:0] mdr,
    input logic [DW-1:0] pc
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (mar == '0 && mdr == '0 && !busy && !done));

    assert_mar_from_bus_R2: assert property (@(posedge clk) disable iff (rst)
        ld_mar |=> (mar == $past(bus)));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_mar_then_mdr_R5: assert property (@(posedge clk) disable iff (rst)
        ld_mar |=> ld_mdr);

    assert_mdr_then_write_R5: assert property (@(posedge clk) disable iff (rst)
        ld_mdr |=> mem_wr);

    assert_write_then_done_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> done);

    assert_one_driver_R6: assert property (@(posedge clk) disable iff (rst)
        $countones({gate_amux, gate_alu}) <= 1);

    assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(pc));

endmodule

bind stseq_top stseq_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .gate_amux (ctl.gate_amux),
    .gate_alu  (ctl.gate_alu),
    .ld_mar    (ctl.ld_mar),
    .ld_mdr    (ctl.ld_mdr),
    .mem_wr    (ctl.mem_wr && ctl.mem_en),
    .busy      (busy),
    .done      (done),
    .bus       (bus),
    .mar       (mar_out),
    .mdr       (mdr_out),
    .pc        (pc_out)
);

// File: tb/tb_stseq_top.sv
module tb_stseq_top;

    localparam int DW = 16;
    localparam int AW = 6;
    localparam int NREG = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, instr_load = 0, pc_load = 0, rf_we = 0, ext_we = 0;
    logic [DW-1:0] instr_in = '0, pc_in = '0, rf_wdata = '0, ext_wdata = '0;
    logic [2:0] rf_waddr = '0, rf_oaddr = '0;
    logic [AW-1:0] ext_addr = '0;
    logic [DW-1:0] rf_odata, ext_rdata, pc_out, mar_out, mdr_out;
    logic busy, done;

    always #5 clk = ~clk;

    stseq_top dut (
        .clk(clk), .rst(rst), .start(start),
        .instr_load(instr_load), .instr_in(instr_in),
        .pc_load(pc_load), .pc_in(pc_in),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_oaddr(rf_oaddr), .rf_odata(rf_odata),
        .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata),
        .pc_out(pc_out), .mar_out(mar_out), .mdr_out(mdr_out),
        .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct { logic [DW-1:0] ea; logic [DW-1:0] data; } item_t;
    item_t q[$];

    logic [DW-1:0] mem_m [DEPTH];
    logic [DW-1:0] reg_m [NREG];
    logic [DW-1:0] pc_m;

    // Monitor: counts busy cycles, pops the scoreboard on each done pulse
    int busy_cnt = 0;
    logic prev_done = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) check("R4 done single cycle", {15'd0, done}, 16'd0);
            if (busy) busy_cnt++;
            if (done) begin
                if (q.size() == 0) begin
                    check("R8 unexpected done", 16'd1, 16'd0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check("R2 R6 MAR effective address", mar_out, it.ea);
                    check("R3 MDR source value", mdr_out, it.data);
                    check("R5 busy cycle count", 16'(busy_cnt), 16'd3);
                end
                busy_cnt = 0;
            end
            prev_done <= done;
        end
    end

    function automatic logic [DW-1:0] ea_of(input logic [DW-1:0] pc, input logic [DW-1:0] ins);
        return pc + {{(DW-9){ins[8]}}, ins[8:0]};
    endfunction

    task automatic set_pc(input logic [DW-1:0] v);
        @(negedge clk); pc_load = 1; pc_in = v;
        @(negedge clk); pc_load = 0;
        pc_m = v;
    endtask

    task automatic verify_state(input string tag);
        int bad = 0;
        for (int a = 0; a < DEPTH; a++) begin
            ext_addr = AW'(a);
            #1;
            if (ext_rdata !== mem_m[a]) bad++;
        end
        check({tag, " R4 R7 memory image mismatches"}, 16'(bad), 16'd0);
        bad = 0;
        for (int r = 0; r < NREG; r++) begin
            rf_oaddr = 3'(r);
            #1;
            if (rf_odata !== reg_m[r]) bad++;
        end
        check({tag, " R7 register mismatches"}, 16'(bad), 16'd0);
        check({tag, " R7 PC unchanged"}, pc_out, pc_m);
    endtask

    task automatic do_store(input logic [DW-1:0] pc, input logic [2:0] src,
                            input logic [8:0] off, input string tag);
        logic [DW-1:0] ins, ea;
        set_pc(pc);
        ins = {4'b0011, src, off};
        ea  = ea_of(pc, ins);
        q.push_back('{ea: ea, data: reg_m[src]});
        mem_m[ea[AW-1:0]] = reg_m[src];
        @(negedge clk); instr_load = 1; instr_in = ins;
        @(negedge clk); instr_load = 0; start = 1;
        @(negedge clk); start = 0;
        check({tag, " R5 busy after start edge"}, {15'd0, busy}, 16'd1);
        repeat (4) @(negedge clk);
        check({tag, " R5 idle after done"}, {15'd0, busy | done}, 16'd0);
        verify_state(tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy after reset", {15'd0, busy}, 16'd0);
        check("R1 done after reset", {15'd0, done}, 16'd0);
        check("R1 MAR after reset", mar_out, 16'd0);
        check("R1 MDR after reset", mdr_out, 16'd0);
        check("R1 PC after reset", pc_out, 16'd0);

        for (int r = 0; r < NREG; r++) begin
            @(negedge clk); rf_we = 1; rf_waddr = 3'(r); rf_wdata = 16'h1000 + 16'(r) * 16'h0111;
            reg_m[r] = rf_wdata;
        end
        @(negedge clk); rf_we = 0;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk); ext_we = 1; ext_addr = AW'(a); ext_wdata = 16'hA000 + 16'(a);
            mem_m[a] = ext_wdata;
        end
        @(negedge clk); ext_we = 0;
        pc_m = 16'd0;

        do_store(16'h0010, 3'd3, 9'h005, "small+");       // R2 R4
        do_store(16'h0020, 3'd7, 9'h1FF, "minus1");       // R9
        do_store(16'h0100, 3'd0, 9'h100, "minus256");     // R9 wraps to 0
        do_store(16'h0000, 3'd5, 9'h0FF, "plus255");      // R9 last word
        do_store(16'hFFF0, 3'd2, 9'h020, "wrap16");       // R9 16-bit wrap

        // R8: second instruction and start during a running store
        begin
            logic [DW-1:0] ins_a, ins_b, ea_a;
            set_pc(16'h0008);
            ins_a = {4'b0011, 3'd6, 9'h002};
            ins_b = {4'b0011, 3'd1, 9'h010};
            ea_a = ea_of(16'h0008, ins_a);
            q.push_back('{ea: ea_a, data: reg_m[6]});
            mem_m[ea_a[AW-1:0]] = reg_m[6];
            @(negedge clk); instr_load = 1; instr_in = ins_a;
            @(negedge clk); instr_load = 0; start = 1;
            @(negedge clk); start = 0;
            instr_load = 1; instr_in = ins_b; pc_load = 1; pc_in = 16'h3333;
            rf_we = 1; rf_waddr = 3'd6; rf_wdata = 16'hDEAD;
            ext_we = 1; ext_addr = 6'd40; ext_wdata = 16'hBEEF;
            @(negedge clk);
            start = 1; instr_load = 0; pc_load = 0; rf_we = 0; ext_we = 0;
            @(negedge clk); start = 0;
            repeat (6) @(negedge clk);
            check("R8 no second store", 16'(q.size()), 16'd0);
            check("R8 idle after ignored start", {15'd0, busy | done}, 16'd0);
            verify_state("R8");
        end

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule